// File: doc/BRIEF.md
# Delay Tap Scan Recorder

This block sweeps an external input delay line through every one of its tap settings. At each tap it records the deserialized loopback word that the receiver produces. When the sweep input is asserted, the controller reads the tap value currently reported by the delay line. It then runs a settling timer. On the last cycle of that wait it stores the incoming word in a result table, at the entry indexed by the tap value it read back.

After each capture it sends a one-cycle increment pulse to the delay line. It reads the new tap value back and waits again. After the final capture it raises a done flag, and from then on the table is frozen. Software or a downstream eye-centering stage reads the table through a synchronous read port, which has one cycle of latency.

The sweep input is sampled only while the block is idle. A second sweep needs a synchronous reset.

Top module: `tap_scan_recorder`

## Requirements
- R1: During and directly after a synchronous reset, `settle_busy`, `tap_step` and `scan_done` are all low.
- R2: While `scan_start` is low after reset, `settle_busy`, `tap_step` and `scan_done` stay low, whatever `rx_word` and `tap_value` do.
- R3: `settle_busy` rises exactly two clock cycles after the first cycle in which `scan_start` is seen high, and exactly two cycles after each `tap_step` cycle. It is low during every `tap_step` cycle.
- R4: Each settling wait keeps `settle_busy` high for exactly `SETTLE_CYCLES` consecutive cycles.
- R5: The word stored for a tap is the value of `rx_word` in the last cycle of its settling wait. It is written to the table entry whose address equals the `tap_value` sampled one cycle after the preceding `tap_step` pulse, or one cycle after the start is seen.
- R6: `tap_step` is high for exactly one cycle per step. A full sweep produces exactly `NUM_TAPS-1` pulses.
- R7: `scan_done` rises on the cycle after the capture for the `NUM_TAPS`-th tap and then stays high until reset.
- R8: Once `scan_done` is high, `tap_step` and `settle_busy` never assert again, and every table entry keeps its value even when `rx_word` and `scan_start` keep changing.
- R9: `rd_word` shows the table entry addressed by `rd_addr` in the previous cycle.
- R10: Dropping `scan_start` in the middle of a sweep does not stop or alter the sweep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_start | input | 1 | Level request to begin the sweep, sampled only when idle |
| rx_word | input | WORD_W | Deserialized loopback word |
| tap_value | input | TAP_W | Current tap reported by the delay line |
| tap_step | output | 1 | One-cycle increment request to the delay line |
| settle_busy | output | 1 | High while the settling timer counts |
| scan_done | output | 1 | Sweep finished, table frozen |
| rd_addr | input | TAP_W | Table read address |
| rd_word | output | WORD_W | Table entry, one cycle after its address |

## Verification
The hardest situation to reach from the ports is to show that a capture uses exactly the last settling cycle, stored at the tap that was read back rather than at an internal count. The bench drives the complement of the expected word on every settling cycle except the last. It starts one of its sweeps with the modelled delay line at a non-zero tap, so the addresses wrap around. Only a capture at the right cycle and the right address then gives the expected table. A sweep is also run with `scan_start` dropped partway through, and after done the bench keeps changing the inputs.

// File: rtl/tap_scan_pkg.sv
package tap_scan_pkg;

  typedef enum logic [2:0] {
    SCAN_IDLE,
    SCAN_READ_TAP,
    SCAN_SETTLE,
    SCAN_STEP,
    SCAN_FINISHED
  } scan_state_t;

endpackage

// File: rtl/tap_scan_timer.sv
module tap_scan_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy,
  output logic expire
);
  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
  localparam logic [CW-1:0] RELOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= RELOAD;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) begin
        run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy   = run_q;
  assign expire = run_q && (cnt_q == '0);
endmodule

// File: rtl/tap_scan_store.sv
module tap_scan_store #(
  parameter int DEPTH  = 32,
  parameter int WORD_W = 10,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tap_scan_ctrl.sv
module tap_scan_ctrl
  import tap_scan_pkg::*;
#(
  parameter int NUM_TAPS = 32,
  localparam int TAP_W   = $clog2(NUM_TAPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scan_start,
  input  logic [TAP_W-1:0] tap_value,
  input  logic             expire,
  output logic             timer_load,
  output logic             store_we,
  output logic [TAP_W-1:0] store_addr,
  output logic             tap_step,
  output logic             scan_done
);
  localparam logic [TAP_W-1:0] LAST_IDX = TAP_W'(NUM_TAPS - 1);

  scan_state_t      state_q;
  logic [TAP_W-1:0] tap_q;
  logic [TAP_W-1:0] taken_q;
  logic             step_q;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SCAN_IDLE;
      tap_q   <= '0;
      taken_q <= '0;
      step_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      case (state_q)
        SCAN_IDLE: begin
          if (scan_start) state_q <= SCAN_READ_TAP;
        end
        SCAN_READ_TAP: begin
          tap_q   <= tap_value;
          state_q <= SCAN_SETTLE;
        end
        SCAN_SETTLE: begin
          if (expire) begin
            if (taken_q == LAST_IDX) begin
              done_q  <= 1'b1;
              state_q <= SCAN_FINISHED;
            end else begin
              taken_q <= taken_q + 1'b1;
              step_q  <= 1'b1;
              state_q <= SCAN_STEP;
            end
          end
        end
        SCAN_STEP: begin
          step_q  <= 1'b0;
          state_q <= SCAN_READ_TAP;
        end
        default: begin
          state_q <= SCAN_FINISHED;
        end
      endcase
    end
  end

  assign timer_load = (state_q == SCAN_READ_TAP);
  assign store_we   = (state_q == SCAN_SETTLE) && expire;
  assign store_addr = tap_q;
  assign tap_step   = step_q;
  assign scan_done  = done_q;
endmodule

// File: rtl/tap_scan_recorder.sv
module tap_scan_recorder #(
  parameter int NUM_TAPS      = 32,
  parameter int WORD_W        = 10,
  parameter int SETTLE_CYCLES = 16,
  localparam int TAP_W        = $clog2(NUM_TAPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_start,
  input  logic [WORD_W-1:0] rx_word,
  input  logic [TAP_W-1:0]  tap_value,
  output logic              tap_step,
  output logic              settle_busy,
  output logic              scan_done,
  input  logic [TAP_W-1:0]  rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  logic             timer_load;
  logic             timer_expire;
  logic             store_we;
  logic [TAP_W-1:0] store_addr;

  tap_scan_ctrl #(.NUM_TAPS(NUM_TAPS)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .scan_start (scan_start),
    .tap_value  (tap_value),
    .expire     (timer_expire),
    .timer_load (timer_load),
    .store_we   (store_we),
    .store_addr (store_addr),
    .tap_step   (tap_step),
    .scan_done  (scan_done)
  );

  tap_scan_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (timer_load),
    .busy   (settle_busy),
    .expire (timer_expire)
  );

  tap_scan_store #(.DEPTH(NUM_TAPS), .WORD_W(WORD_W)) u_store (
    .clk   (clk),
    .we    (store_we),
    .waddr (store_addr),
    .wdata (rx_word),
    .raddr (rd_addr),
    .rdata (rd_word)
  );
endmodule

// File: rtl/tap_scan_recorder_chk.sv
module tap_scan_recorder_chk #(
  parameter int TAP_W  = 5,
  parameter int WORD_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              tap_step,
  input logic              settle_busy,
  input logic              scan_done,
  input logic [TAP_W-1:0]  rd_addr,
  input logic [WORD_W-1:0] rd_word
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!settle_busy && !tap_step && !scan_done));

  assert_step_single_R6: assert property (@(posedge clk) disable iff (rst)
    tap_step |=> !tap_step);

  assert_step_not_busy_R3: assert property (@(posedge clk) disable iff (rst)
    tap_step |-> !settle_busy);

  assert_busy_after_step_R3: assert property (@(posedge clk) disable iff (rst)
    tap_step |=> !settle_busy ##1 settle_busy);

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    scan_done |=> scan_done);

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    scan_done |-> (!tap_step && !settle_busy));

  assert_table_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (scan_done && $past(scan_done) && rd_addr == $past(rd_addr)) |=> $stable(rd_word));
endmodule

bind tap_scan_recorder tap_scan_recorder_chk #(.TAP_W(TAP_W), .WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tap_step    (tap_step),
  .settle_busy (settle_busy),
  .scan_done   (scan_done),
  .rd_addr     (rd_addr),
  .rd_word     (rd_word)
);

// File: tb/tap_scan_recorder_test.sv
module tap_scan_recorder_test;
  localparam int NT = 32;
  localparam int WW = 10;
  localparam int SC = 5;
  localparam int TW = $clog2(NT);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          scan_start = 1'b0;
  logic [WW-1:0] rx_word = '0;
  logic [TW-1:0] tap_model;
  logic [TW-1:0] tap_init = '0;
  logic          tap_step, settle_busy, scan_done;
  logic [TW-1:0] rd_addr = '0;
  logic [WW-1:0] rd_word;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  int seed = 0;
  bit mon_en = 1'b0;
  int run_len = 0;
  int since_ev = 100;
  int steps = 0;
  bit prev_busy = 1'b0, prev_step = 1'b0, prev_done = 1'b0, prev_start = 1'b0;

  always #5 clk = ~clk;

  tap_scan_recorder #(.NUM_TAPS(NT), .WORD_W(WW), .SETTLE_CYCLES(SC)) uut (
    .clk(clk), .rst(rst), .scan_start(scan_start), .rx_word(rx_word),
    .tap_value(tap_model), .tap_step(tap_step), .settle_busy(settle_busy),
    .scan_done(scan_done), .rd_addr(rd_addr), .rd_word(rd_word)
  );

  // delay line model: steps by one on each increment pulse
  always @(posedge clk) begin
    if (rst) tap_model <= tap_init;
    else if (tap_step) tap_model <= tap_model + 1'b1;
  end

  function automatic logic [WW-1:0] wfun(int s, int t);
    return WW'((t * 41 + s * 97 + 3) & ((1 << WW) - 1));
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      summary();
    end
  end

  // per-cycle monitor, samples away from the active edge
  always @(negedge clk) begin
    if (mon_en) begin
      if (scan_start && !prev_start) since_ev = 0;
      else if (tap_step) since_ev = 0;
      else since_ev++;
      if (settle_busy) begin
        run_len++;
        rx_word = (run_len == SC) ? wfun(seed, int'(tap_model)) : ~wfun(seed, int'(tap_model));
        if (!prev_busy) chk(since_ev == 2, "R3 busy rise delay", since_ev, 2);
      end else begin
        if (run_len != 0) chk(run_len == SC, "R4 settle length", run_len, SC);
        run_len = 0;
        rx_word = WW'(cycles * 13);
      end
      if (tap_step) begin
        steps++;
        chk(!prev_step, "R6 single-cycle step", 2, 1);
        chk(!settle_busy, "R3 busy low on step", int'(settle_busy), 0);
      end
      if (prev_done) begin
        chk(scan_done, "R7 done sticky", int'(scan_done), 1);
        chk(!tap_step && !settle_busy, "R8 quiet after done",
            int'(tap_step) + int'(settle_busy), 0);
      end
      if (scan_done && !prev_done)
        chk(steps == NT - 1, "R6 step count", steps, NT - 1);
      prev_busy = settle_busy;
      prev_step = tap_step;
      prev_done = scan_done;
      prev_start = scan_start;
    end
  end

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic run_scan(int s, int t0, bit drop_start);
    seed = s;
    tap_init = TW'(t0);
    mon_en = 1'b0;
    scan_start = 1'b0;
    rst = 1'b1;
    repeat (3) tick();
    // R1 outputs during reset
    chk(!settle_busy && !tap_step && !scan_done, "R1 reset outputs",
        int'(settle_busy) + int'(tap_step) + int'(scan_done), 0);
    rst = 1'b0;
    run_len = 0; steps = 0; since_ev = 100;
    prev_busy = 0; prev_step = 0; prev_done = 0; prev_start = 0;
    mon_en = 1'b1;
    tick();
    chk(!settle_busy && !tap_step && !scan_done, "R1 after reset",
        int'(settle_busy) + int'(tap_step) + int'(scan_done), 0);
    for (int i = 0; i < 8; i++) begin
      tick();
      chk(!settle_busy && !tap_step && !scan_done, "R2 idle without start",
          int'(settle_busy) + int'(tap_step) + int'(scan_done), 0);
    end
    scan_start = 1'b1;
    for (int i = 0; i < 2000 && !scan_done; i++) begin
      tick();
      if (drop_start && steps == 3) scan_start = 1'b0; // R10
    end
    chk(scan_done, "R7 done reached", int'(scan_done), 1);
    // R8: inputs keep moving after done
    for (int i = 0; i < 40; i++) begin
      scan_start = i[0];
      tick();
    end
    // R5/R9/R8: read back the whole table
    for (int a = 0; a < NT; a++) begin
      rd_addr = TW'(a);
      tick();
      chk(rd_word == wfun(s, a), "R5 R9 stored word", int'(rd_word), int'(wfun(s, a)));
    end
    // R9: reverse order, one cycle latency per address
    for (int a = NT - 1; a >= 0; a--) begin
      rd_addr = TW'(a);
      tick();
      chk(rd_word == wfun(s, a), "R9 R8 reverse read", int'(rd_word), int'(wfun(s, a)));
    end
    mon_en = 1'b0;
  endtask

  initial begin
    run_scan(1, 0, 1'b0);
    run_scan(2, 7, 1'b1);
    run_scan(3, 31, 1'b0);
    summary();
  end
endmodule